// File: doc/BRIEF.md
# Supply Supervisor Watchdog Sequencer

This block sequences the three supervisory outputs of a supply monitor from digital flags. Comparators elsewhere report whether the monitored line is above the power-on level, the save-warning level and the reset level. A separate flag reports whether the supply rail is valid. From these flags and a watchdog clear input the block produces an active-low save warning, an active-low reset and an active-high reset.

On power-up the block waits a debounce delay, then releases the save warning. It keeps the resets active for one timeout period (initialization), then releases them and starts the watchdog. Software must then pulse the clear input low within every timeout period. If a period passes with no qualified clear, the resets are asserted for one timeout period and then released for another attempt. With no clears at all, the reset pins therefore toggle with a period of two timeouts.

On a falling supply, the save output warns first. The resets follow when the reset level is crossed, and the whole power-up sequence runs again on recovery. All periods are counted in clock cycles.

Top module: `supply_wdog_seq`

## Requirements
- R1: While `rst` is high, all outputs are active on the next clock edge: `save_n`=0, `rst_n`=0, `rst_p`=1.
- R2: Before start-up completes, `save_n` and `rst_n` stay 0 as long as any of these is low: `vin_above_on`, `vin_above_rst` or `supply_ok`.
- R3: Counting starts at the first clock edge that samples all three start-up flags high. `save_n` rises on the DEB_CYC-th edge after that edge. If a flag drops during the count, the count restarts from the beginning.
- R4: `rst_n` rises exactly TO_CYC clock edges after `save_n` rises at the end of start-up. Clear events have no influence on this interval.
- R5: After `rst_n` rises, it falls TO_CYC edges after the rise or after the last accepted clear, whichever is later. Each timeout reset lasts TO_CYC edges and then releases `rst_n`. With no clears, `rst_n` is high for TO_CYC cycles and low for TO_CYC cycles, repeating.
- R6: An accepted clear during a timeout reset raises `rst_n` on the edge where the event is seen. A new TO_CYC window then starts from that edge.
- R7: The clear input passes through a two-flop synchronizer. A low level held for at least MIN_LOW_CYC clock cycles produces exactly one clear event, seen by the sequencer MIN_LOW_CYC+2 edges after the first edge that samples the low. Shorter low pulses produce no event.
- R8: Clear events are ignored before `rst_n` first rises, and while `vin_above_on` is low.
- R9: After start-up, `save_n` follows `vin_above_save` with one cycle of latency and leaves the resets unchanged.
- R10: After start-up, if `vin_above_rst` or `supply_ok` goes low, all outputs go active on the next edge. Recovery reruns the full debounce and initialization sequence.
- R11: `rst_p` is always the inverse of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_above_on | input | 1 | Monitored line above the power-on level |
| vin_above_save | input | 1 | Monitored line above the save-warning level |
| vin_above_rst | input | 1 | Monitored line above the reset level |
| supply_ok | input | 1 | Supply rail valid |
| wd_clear | input | 1 | Watchdog clear input; asynchronous, falling edges count |
| save_n | output | 1 | Save warning, active low |
| rst_n | output | 1 | Reset, active low |
| rst_p | output | 1 | Reset, active high |

## Verification
The assertions check four things on every cycle. The held state is all-active. A low save flag or a brown-out reaches the outputs within one edge. An accepted clear ends a timeout reset. A clear event is a single-cycle pulse, and the period counter never passes its limit. Only the bench scenarios can show the exact lengths of the debounce, initialization, timeout and square-wave intervals. The same holds for the boundary between an accepted and a rejected clear width, for clears being ignored during initialization or below the power-on level, and for full re-initialization after recovery.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [2:0] {
    ST_HOLD     = 3'd0,
    ST_DEBOUNCE = 3'd1,
    ST_INIT     = 3'd2,
    ST_RUN      = 3'd3,
    ST_WDRST    = 3'd4
  } swd_state_e;
endpackage

// File: rtl/swd_clear_qual.sv
module swd_clear_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_in,
  output logic clr_evt
);
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] LOW_MAX  = LW'(MIN_LOW_CYC);
  localparam logic [LW-1:0] LOW_FIRE = LW'(MIN_LOW_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LW-1:0]          low_q;
  logic                   evt_q;
  logic                   clr_s;

  assign clr_s = sync_q[SYNC_STAGES-1];

  // synchronizer chain, idles high
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], clr_in};
  end

  // low-width counter saturates so a long low gives one event
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (clr_s)                low_q <= '0;
      else if (low_q != LOW_MAX) low_q <= low_q + 1'b1;
      evt_q <= !clr_s && (low_q == LOW_FIRE);
    end
  end

  assign clr_evt = evt_q;

  // R7: one event per qualified low level
  p_evt_single_r7: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
endmodule

// File: rtl/swd_period_cnt.sv
module swd_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || hit) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R5: the period count never runs past its limit
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit);
endmodule

// File: rtl/swd_seq_fsm.sv
module swd_seq_fsm
  import swd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vin_on,
  input  logic vin_save,
  input  logic vin_rst,
  input  logic supply_ok,
  input  logic clr_evt,
  input  logic tmo_hit,
  output logic restart,
  output logic use_deb,
  output logic save_n,
  output logic rst_n,
  output logic rst_p
);
  swd_state_e state_q, state_d;
  logic save_n_q, rst_n_q, rst_p_q;
  logic start_ok, fail, clr_ok, keep;

  assign start_ok = vin_on && vin_rst && supply_ok;
  assign fail     = !vin_rst || !supply_ok;
  assign clr_ok   = clr_evt && vin_on;

  always_comb begin
    state_d = state_q;
    keep    = 1'b0;
    unique case (state_q)
      ST_HOLD:     if (start_ok) state_d = ST_DEBOUNCE;
      ST_DEBOUNCE: begin
        if (!start_ok)    state_d = ST_HOLD;
        else if (tmo_hit) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (fail)         state_d = ST_HOLD;
        else if (tmo_hit) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (fail)         state_d = ST_HOLD;
        else if (clr_ok)  keep    = 1'b1;
        else if (tmo_hit) state_d = ST_WDRST;
      end
      ST_WDRST: begin
        if (fail)                   state_d = ST_HOLD;
        else if (clr_ok || tmo_hit) state_d = ST_RUN;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  assign restart = (state_d != state_q) || keep || (state_q == ST_HOLD);
  assign use_deb = (state_q == ST_DEBOUNCE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HOLD;
      save_n_q <= 1'b0;
      rst_n_q  <= 1'b0;
      rst_p_q  <= 1'b1;
    end else begin
      state_q  <= state_d;
      save_n_q <= vin_save && (state_d == ST_INIT || state_d == ST_RUN ||
                               state_d == ST_WDRST);
      rst_n_q  <= (state_d == ST_RUN);
      rst_p_q  <= (state_d != ST_RUN);
    end
  end

  assign save_n = save_n_q;
  assign rst_n  = rst_n_q;
  assign rst_p  = rst_p_q;

  // R2: the held state keeps every output active
  p_hold_active_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> (!save_n_q && !rst_n_q));
  // R9: a low save flag is visible at save_n one edge later
  p_save_warn_r9: assert property (@(posedge clk) disable iff (rst)
    !vin_save |=> !save_n_q);
  // R10: brown-out or bad supply activates all outputs on the next edge
  p_brownout_r10: assert property (@(posedge clk) disable iff (rst)
    fail |=> (!save_n_q && !rst_n_q && rst_p_q));
  // R6: an accepted clear ends a timeout reset immediately
  p_clear_ends_wdrst_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WDRST && clr_ok && !fail) |=> rst_n_q);
endmodule

// File: rtl/supply_wdog_seq.sv
module supply_wdog_seq #(
  parameter int DEB_CYC     = 1000,
  parameter int TO_CYC      = 10_000_000,
  parameter int MIN_LOW_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic vin_above_on,
  input  logic vin_above_save,
  input  logic vin_above_rst,
  input  logic supply_ok,
  input  logic wd_clear,
  output logic save_n,
  output logic rst_n,
  output logic rst_p
);
  localparam int MAX_CYC = (DEB_CYC > TO_CYC) ? DEB_CYC : TO_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LIM_DEB = CNT_W'(DEB_CYC);
  localparam logic [CNT_W-1:0] LIM_TO  = CNT_W'(TO_CYC);

  logic clr_evt, tmo_hit, restart, use_deb;
  logic [CNT_W-1:0] limit;

  assign limit = use_deb ? LIM_DEB : LIM_TO;

  swd_clear_qual #(
    .SYNC_STAGES (2),
    .MIN_LOW_CYC (MIN_LOW_CYC)
  ) u_qual (
    .clk     (clk),
    .rst     (rst),
    .clr_in  (wd_clear),
    .clr_evt (clr_evt)
  );

  swd_period_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .limit   (limit),
    .hit     (tmo_hit)
  );

  swd_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .vin_on    (vin_above_on),
    .vin_save  (vin_above_save),
    .vin_rst   (vin_above_rst),
    .supply_ok (supply_ok),
    .clr_evt   (clr_evt),
    .tmo_hit   (tmo_hit),
    .restart   (restart),
    .use_deb   (use_deb),
    .save_n    (save_n),
    .rst_n     (rst_n),
    .rst_p     (rst_p)
  );
endmodule

// File: tb/sim_supply_wdog_seq.sv
module sim_supply_wdog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int TO  = 20;
  localparam int MINW = 3;
  localparam int WD_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin_above_on, vin_above_save, vin_above_rst, supply_ok, wd_clear;
  logic save_n, rst_n, rst_p;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_wdog_seq #(.DEB_CYC(DEB), .TO_CYC(TO), .MIN_LOW_CYC(MINW)) u0 (
    .clk(clk), .rst(rst), .vin_above_on(vin_above_on),
    .vin_above_save(vin_above_save), .vin_above_rst(vin_above_rst),
    .supply_ok(supply_ok), .wd_clear(wd_clear),
    .save_n(save_n), .rst_n(rst_n), .rst_p(rst_p));

  // entry: {on,save,rst,ok,clr}[14:10], hold cycles [9:2], {save_n,rst_n}[1:0]
  localparam logic [14:0] VEC [0:10] = '{
    {5'b00011, 8'd5,  2'b00},
    {5'b11111, 8'd3,  2'b00},
    {5'b11111, 8'd10, 2'b10},
    {5'b11111, 8'd15, 2'b11},
    {5'b10111, 8'd2,  2'b01},
    {5'b11111, 8'd2,  2'b11},
    {5'b00011, 8'd2,  2'b00},
    {5'b11111, 8'd3,  2'b00},
    {5'b11111, 8'd4,  2'b10},
    {5'b11111, 8'd25, 2'b11},
    {5'b11101, 8'd2,  2'b00}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R9";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic set_in(input logic [4:0] v);
    {vin_above_on, vin_above_save, vin_above_rst, supply_ok, wd_clear} = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic es, input logic er);
    n_chk++;
    if (save_n !== es || rst_n !== er) begin
      n_bad++;
      $display("FAIL %s: got save_n=%0b rst_n=%0b expected save_n=%0b rst_n=%0b",
               tag, save_n, rst_n, es, er);
    end
    n_chk++;
    if (rst_p !== ~rst_n) begin
      n_bad++;
      $display("FAIL R11: got rst_p=%0b expected %0b", rst_p, ~rst_n);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    set_in(5'b00011);
    step(2);
    chk("R1", 1'b0, 1'b0);
    rst = 1'b0;

    // table walk: power-up, warning, brown-out, recovery, bad supply
    for (int i = 0; i < 11; i++) begin
      set_in(VEC[i][14:10]);
      step(int'(VEC[i][9:2]));
      chk(vec_tag(i), VEC[i][1], VEC[i][0]);
    end

    // exact start-up edges
    rst = 1'b1;
    set_in(5'b11111);
    step(2);
    chk("R1", 1'b0, 1'b0);
    rst = 1'b0;
    step(DEB);    chk("R3", 1'b0, 1'b0);
    step(1);      chk("R3", 1'b1, 1'b0);
    step(TO-1);   chk("R4", 1'b1, 1'b0);
    step(1);      chk("R4", 1'b1, 1'b1);

    // square wave with no clears
    step(TO-1);   chk("R5", 1'b1, 1'b1);
    step(1);      chk("R5", 1'b1, 1'b0);
    step(TO-1);   chk("R5", 1'b1, 1'b0);
    step(1);      chk("R5", 1'b1, 1'b1);

    // low pulse one cycle short of the minimum is ignored
    set_in(5'b11110); step(MINW-1);
    set_in(5'b11111); step(TO-1-(MINW-1));
    chk("R7", 1'b1, 1'b1);
    step(1);      chk("R7", 1'b1, 1'b0);

    // minimum-width clear ends the timeout reset on the expected edge
    set_in(5'b11110); step(MINW);
    set_in(5'b11111); step(2);
    chk("R7", 1'b1, 1'b0);
    step(1);      chk("R6", 1'b1, 1'b1);
    step(TO-1);   chk("R6", 1'b1, 1'b1);
    step(1);      chk("R6", 1'b1, 1'b0);

    // periodic clears keep the reset released
    step(TO);     chk("R5", 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      set_in(5'b11110); step(MINW);
      set_in(5'b11111); step(TO/2 - MINW);
    end
    chk("R6", 1'b1, 1'b1);
    step(TO);     chk("R5", 1'b1, 1'b0);
    step(16);     chk("R5", 1'b1, 1'b1);

    // clear below the power-on level is ignored
    set_in(5'b01110); step(MINW);
    set_in(5'b01111); step(TO-1-MINW);
    chk("R8", 1'b1, 1'b1);
    step(1);      chk("R8", 1'b1, 1'b0);
    set_in(5'b11111);
    step(TO);     chk("R5", 1'b1, 1'b1);

    // warning, then bad supply, while running
    set_in(5'b10111); step(1); chk("R9", 1'b0, 1'b1);
    set_in(5'b11111); step(1); chk("R9", 1'b1, 1'b1);
    set_in(5'b11101); step(1); chk("R10", 1'b0, 1'b0);

    // recovery reruns start-up; clears during init are ignored
    set_in(5'b11111);
    step(DEB);    chk("R10", 1'b0, 1'b0);
    step(1);      chk("R10", 1'b1, 1'b0);
    set_in(5'b11110); step(MINW);
    set_in(5'b11111); step(TO-1-MINW);
    chk("R8", 1'b1, 1'b0);
    step(1);      chk("R8", 1'b1, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule